// File: doc/BRIEF.md
# Switch Configuration SPI Register Port

This block is an SPI slave that lets a host processor read and write the byte-wide configuration registers of a small five-port managed Ethernet switch. The host sends fixed frames of three bytes: an opcode, an 8-bit register address and one data byte. On a read frame, the slave returns the addressed register on MISO while the third byte is clocked. On a write frame, the third byte is committed to the register once its last bit has been sampled.

SCK, chip select and MOSI are brought into the system clock domain through synchronisers. A frame engine turns the bit stream into a single-cycle internal register bus: an address, write data, a write strobe and combinational read data. That bus serves a register file with the following contents:
- a read-only identity byte;
- a control byte whose low bit starts the switch;
- four general control bytes, one of which carries the VLAN enable flag;
- five per-port banks of sixteen bytes each, laid out at a fixed stride.

The start and VLAN enable flags are driven out as ports for the switching fabric.

Top module: `swcfg_spi_port`

## Requirements
- R1: After reset, MISO is 0, switch_start is 0 and vlan_enable is 0, and MISO stays 0 while chip select is high.
- R2: Opcode 0x03 is a read. The slave returns 0x00 during the first two bytes, then the register at the address byte during the third byte, MSB first. The host samples each MISO bit before the SCK rising edge of that bit (SPI mode 0).
- R3: Opcode 0x02 is a write. The register at the address byte takes the third byte once all 24 bits have been clocked. A later read returns that value.
- R4: Register 0x00 always reads 0x95 and ignores writes. The upper nibble of register 0x01 always reads 0x0.
- R5: Bit 0 of register 0x01 is the start flag. Writing 0x01 to 0x01 raises switch_start, writing 0x00 lowers it, and the register reads back the flag in bit 0.
- R6: Registers 0x02 to 0x05 are plain read/write bytes. Bit 7 of register 0x05 drives vlan_enable, so a read-modify-write can set or clear that flag and keep the other seven bits.
- R7: Port p (0 to 4) owns addresses 0x10+0x10*p to 0x1F+0x10*p, with separate storage per byte. Addresses 0x06 to 0x0F and 0x60 to 0xFF read 0 and ignore writes.
- R8: Raising chip select before the 24th bit aborts the frame, and no register changes. The next frame starts again at the opcode byte.
- R9: An opcode other than 0x02 or 0x03 changes no register, and MISO stays 0 for the whole frame.
- R10: Bits clocked after the 24th bit of a frame are ignored. A frame performs at most one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| switch_start | output | 1 | Start flag, bit 0 of register 0x01 |
| vlan_enable | output | 1 | VLAN enable flag, bit 7 of register 0x05 |

## Verification
Reads use patterns with alternating bits, such as 0xA5 and 0x5A, so that a swapped bit order, a missing bit or a one-bit slip in the MISO shift stands out from a correct frame. Writes go to every port bank at two different offsets, which separates stride or offset decoding faults from plain storage faults. Reads from unmapped addresses and writes to them cover the edges of the decode. Three frame shapes test the framing logic: frames cut short after 8 and after 20 bits, a 32-bit frame carrying a fourth byte, and an unknown opcode aimed at a non-zero register. Each can only be told apart by a read-back or by the MISO stream staying zero.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] ID_FAMILY = 8'h95;
    localparam int FRAME_BITS = 24;
    localparam int BYTE_BITS  = 8;
endpackage

// File: rtl/swcfg_spi_sync.sv
module swcfg_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mosi;
        logic              sck_last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0], sck_i};
        sync_d.csn      = {sync_q.csn[STAGES-2:0], cs_n_i};
        sync_d.mosi     = {sync_q.mosi[STAGES-2:0], mosi_i};
        sync_d.sck_last = sync_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q          <= '0;
            sync_q.csn      <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sck_rise  = sync_q.sck[STAGES-1] & ~sync_q.sck_last;
    assign sck_fall  = ~sync_q.sck[STAGES-1] & sync_q.sck_last;
    assign cs_active = ~sync_q.csn[STAGES-1];
    assign mosi_s    = sync_q.mosi[STAGES-1];
endmodule

// File: rtl/swcfg_spi_frame.sv
module swcfg_spi_frame
    import swcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       cs_active,
    input  logic       mosi_s,
    input  logic [7:0] rd_data,
    output logic       miso,
    output logic       wr_en,
    output logic [7:0] addr,
    output logic [7:0] wdata
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] CNT_CMD  = CW'(BYTE_BITS - 1);
    localparam logic [CW-1:0] CNT_ADDR = CW'(2 * BYTE_BITS - 1);
    localparam logic [CW-1:0] CNT_DATA = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(FRAME_BITS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [7:0]    rx;
        logic [7:0]    cmd;
        logic [7:0]    addr;
        logic [7:0]    tx;
        logic          load;
        logic          miso;
        logic          wr;
        logic [7:0]    wdata;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [7:0] rx_next;

    assign rx_next = {fr_q.rx[6:0], mosi_s};

    always_comb begin
        fr_d      = fr_q;
        fr_d.wr   = 1'b0;
        fr_d.load = 1'b0;
        if (!cs_active) begin
            fr_d.cnt  = '0;
            fr_d.tx   = '0;
            fr_d.miso = 1'b0;
            fr_d.cmd  = '0;
        end else begin
            if (sck_rise && fr_q.cnt != CNT_DONE) begin
                fr_d.rx  = rx_next;
                fr_d.cnt = fr_q.cnt + 1'b1;
                if (fr_q.cnt == CNT_CMD) begin
                    fr_d.cmd = rx_next;
                end
                if (fr_q.cnt == CNT_ADDR) begin
                    fr_d.addr = rx_next;
                    fr_d.load = (fr_q.cmd == OP_READ);
                end
                if (fr_q.cnt == CNT_DATA && fr_q.cmd == OP_WRITE) begin
                    fr_d.wr    = 1'b1;
                    fr_d.wdata = rx_next;
                end
            end
            if (sck_fall) begin
                fr_d.miso = fr_q.tx[7];
                fr_d.tx   = {fr_q.tx[6:0], 1'b0};
            end
            if (fr_q.load) begin
                fr_d.tx = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign miso  = fr_q.miso;
    assign wr_en = fr_q.wr;
    assign addr  = fr_q.addr;
    assign wdata = fr_q.wdata;
endmodule

// File: rtl/swcfg_regfile.sv
module swcfg_regfile
    import swcfg_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int BANK_BASE   = 16,
    parameter int BANK_STRIDE = 16,
    parameter int GCTL_BASE   = 2,
    parameter int GCTL_NUM    = 4,
    parameter int VLAN_REG    = 5,
    parameter int VLAN_BIT    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       start_o,
    output logic       vlan_o
);
    localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int OW       = (BANK_STRIDE > 1) ? $clog2(BANK_STRIDE) : 1;
    localparam int GW       = (GCTL_NUM > 1) ? $clog2(GCTL_NUM) : 1;
    localparam int BANK_END = BANK_BASE + NUM_PORTS * BANK_STRIDE;
    localparam int GCTL_END = GCTL_BASE + GCTL_NUM;
    localparam int VIDX     = VLAN_REG - GCTL_BASE;
    localparam int ID_REG   = 0;
    localparam int CTRL_REG = 1;

    typedef struct packed {
        logic                                     start;
        logic [GCTL_NUM-1:0][7:0]                 gctl;
        logic [NUM_PORTS-1:0][BANK_STRIDE-1:0][7:0] bank;
    } regs_t;

    regs_t rg_d, rg_q;

    int            a_int;
    int            rel;
    logic          in_bank;
    logic          in_gctl;
    logic [PW-1:0] pidx;
    logic [OW-1:0] oidx;
    logic [GW-1:0] gidx;

    always_comb begin
        a_int   = int'(addr);
        rel     = a_int - BANK_BASE;
        in_bank = (a_int >= BANK_BASE) && (a_int < BANK_END);
        in_gctl = (a_int >= GCTL_BASE) && (a_int < GCTL_END);
        pidx    = PW'(rel / BANK_STRIDE);
        oidx    = OW'(rel % BANK_STRIDE);
        gidx    = GW'(a_int - GCTL_BASE);
    end

    always_comb begin
        if (a_int == ID_REG) begin
            rdata = ID_FAMILY;
        end else if (a_int == CTRL_REG) begin
            rdata = {7'b0, rg_q.start};
        end else if (in_gctl) begin
            rdata = rg_q.gctl[gidx];
        end else if (in_bank) begin
            rdata = rg_q.bank[pidx][oidx];
        end else begin
            rdata = 8'h00;
        end
    end

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (a_int == CTRL_REG) begin
                rg_d.start = wdata[0];
            end else if (in_gctl) begin
                rg_d.gctl[gidx] = wdata;
            end else if (in_bank) begin
                rg_d.bank[pidx][oidx] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign start_o = rg_q.start;
    assign vlan_o  = rg_q.gctl[VIDX][VLAN_BIT];
endmodule

// File: rtl/swcfg_spi_port.sv
module swcfg_spi_port #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_PORTS   = 5,
    parameter int BANK_BASE   = 16,
    parameter int BANK_STRIDE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic switch_start,
    output logic vlan_enable
);
    logic       sck_rise;
    logic       sck_fall;
    logic       cs_active;
    logic       mosi_s;
    logic       reg_wr;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    swcfg_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (spi_sck),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    swcfg_spi_frame frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s),
        .rd_data   (reg_rdata),
        .miso      (spi_miso),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata)
    );

    swcfg_regfile #(
        .NUM_PORTS   (NUM_PORTS),
        .BANK_BASE   (BANK_BASE),
        .BANK_STRIDE (BANK_STRIDE)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .start_o (switch_start),
        .vlan_o  (vlan_enable)
    );
endmodule

// File: rtl/swcfg_spi_port_chk.sv
module swcfg_spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_miso,
    input logic       switch_start,
    input logic       vlan_enable,
    input logic       cs_active,
    input logic       reg_wr,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata
);
    assert_idle_miso_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !spi_miso);

    assert_id_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h00) |-> (reg_rdata == 8'h95));

    assert_start_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_start != $past(switch_start)) |->
            ($past(reg_wr) && $past(reg_addr) == 8'h01));

    assert_vlan_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vlan_enable != $past(vlan_enable)) |->
            ($past(reg_wr) && $past(reg_addr) == 8'h05 && $past(reg_wdata[7]) == vlan_enable));

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && $past(!cs_active)) |-> !reg_wr);

    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
endmodule

bind swcfg_spi_port swcfg_spi_port_chk chk_i (.*);

// File: tb/swcfg_spi_port_tb.sv
`timescale 1ns/1ps
module swcfg_spi_port_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic switch_start;
    logic vlan_enable;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    swcfg_spi_port dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck      (spi_sck),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .switch_start (switch_start),
        .vlan_enable  (vlan_enable)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
        rx = '0;
        spi_cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[31-i];
            wait_clks(HALF);
            rx = {rx[30:0], spi_miso};
            spi_sck = 1'b1;
            wait_clks(HALF);
            spi_sck = 1'b0;
        end
        wait_clks(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_clks(3 * HALF);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        logic [31:0] rx;
        spi_frame({8'h02, a, d, 8'h00}, 24, rx);
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output logic [15:0] head);
        logic [31:0] rx;
        spi_frame({8'h03, a, 8'h00, 8'h00}, 24, rx);
        d = rx[7:0];
        head = rx[23:8];
    endtask

    task automatic t_reset();
        check("R1 miso after reset", 32'(spi_miso), 32'h0);
        check("R1 start after reset", 32'(switch_start), 32'h0);
        check("R1 vlan after reset", 32'(vlan_enable), 32'h0);
    endtask

    task automatic t_identity();
        logic [7:0] d;
        logic [15:0] h;
        reg_read(8'h00, d, h);
        check("R4 family code", 32'(d), 32'h95);
        check("R2 first two bytes zero", 32'(h), 32'h0);
        reg_write(8'h00, 8'h5A);
        reg_read(8'h00, d, h);
        check("R4 id ignores write", 32'(d), 32'h95);
        reg_read(8'h01, d, h);
        check("R4 reg1 upper nibble", 32'(d[7:4]), 32'h0);
    endtask

    task automatic t_start();
        logic [7:0] d;
        logic [15:0] h;
        reg_write(8'h01, 8'h01);
        check("R5 start raised", 32'(switch_start), 32'h1);
        reg_read(8'h01, d, h);
        check("R5 reg1 reads start", 32'(d), 32'h01);
        reg_write(8'h01, 8'h00);
        check("R5 start lowered", 32'(switch_start), 32'h0);
    endtask

    task automatic t_gctl();
        logic [7:0] d;
        logic [15:0] h;
        reg_write(8'h05, 8'h3C);
        reg_read(8'h05, d, h);
        check("R3 write/read 0x05", 32'(d), 32'h3C);
        check("R6 vlan off", 32'(vlan_enable), 32'h0);
        reg_write(8'h05, d | 8'h80);
        reg_read(8'h05, d, h);
        check("R6 rmw set keeps bits", 32'(d), 32'hBC);
        check("R6 vlan on", 32'(vlan_enable), 32'h1);
        reg_write(8'h05, d & 8'h7F);
        check("R6 vlan off again", 32'(vlan_enable), 32'h0);
        reg_write(8'h02, 8'hA5);
        reg_read(8'h02, d, h);
        check("R2 pattern A5 msb first", 32'(d), 32'hA5);
        reg_write(8'h04, 8'h5A);
        reg_read(8'h04, d, h);
        check("R2 pattern 5A msb first", 32'(d), 32'h5A);
    endtask

    task automatic t_banks();
        logic [7:0] d;
        logic [15:0] h;
        for (int p = 0; p < 5; p++) begin
            reg_write(8'(8'h10 + 16 * p + p), 8'(8'hA0 + p));
            reg_write(8'(8'h1F + 16 * p), 8'(8'h50 + p));
        end
        for (int p = 0; p < 5; p++) begin
            reg_read(8'(8'h10 + 16 * p + p), d, h);
            check($sformatf("R7 port %0d low offset", p), 32'(d), 32'(8'hA0 + p));
            reg_read(8'(8'h1F + 16 * p), d, h);
            check($sformatf("R7 port %0d top offset", p), 32'(d), 32'(8'h50 + p));
        end
        reg_write(8'h60, 8'hFF);
        reg_read(8'h60, d, h);
        check("R7 above last bank", 32'(d), 32'h0);
        reg_write(8'h08, 8'hFF);
        reg_read(8'h08, d, h);
        check("R7 gap below banks", 32'(d), 32'h0);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        logic [15:0] h;
        logic [31:0] rx;
        spi_frame({8'h02, 8'h12, 8'hEE, 8'h00}, 20, rx);
        reg_read(8'h12, d, h);
        check("R8 abort after 20 bits", 32'(d), 32'h00);
        spi_frame({8'h02, 8'h00, 8'h00, 8'h00}, 8, rx);
        reg_write(8'h12, 8'h77);
        reg_read(8'h12, d, h);
        check("R8 fresh frame after abort", 32'(d), 32'h77);
    endtask

    task automatic t_badcmd();
        logic [7:0] d;
        logic [15:0] h;
        logic [31:0] rx;
        reg_write(8'h03, 8'hC3);
        spi_frame({8'h07, 8'h03, 8'h11, 8'h00}, 24, rx);
        check("R9 miso zero on bad opcode", rx, 32'h0);
        spi_frame({8'h82, 8'h03, 8'h11, 8'h00}, 24, rx);
        reg_read(8'h03, d, h);
        check("R9 no write on bad opcode", 32'(d), 32'hC3);
    endtask

    task automatic t_extra();
        logic [7:0] d;
        logic [15:0] h;
        logic [31:0] rx;
        spi_frame({8'h02, 8'h13, 8'h55, 8'hAA}, 32, rx);
        reg_read(8'h13, d, h);
        check("R10 extra byte ignored", 32'(d), 32'h55);
        reg_read(8'hAA, d, h);
        check("R10 no second write", 32'(d), 32'h00);
        reg_read(8'h55, d, h);
        check("R10 no write at data as address", 32'(d), 32'h00);
    endtask

    initial begin
        wait_clks(10);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset();
        t_identity();
        t_start();
        t_gctl();
        t_banks();
        t_abort();
        t_badcmd();
        t_extra();
        check("R1 miso idle at end", 32'(spi_miso), 32'h0);
        summary();
    end
endmodule